// File: doc/BRIEF.md
# I2C Bus Master with Flag-Gated Operations

This block is a single-master I2C controller that software steers one bus step at a time. A write port reaches three registers: a bit-rate divisor, a control register and a data register. Software picks an operation with the control bits: START (also used as repeated START), STOP, or a byte transfer. It then writes a 1 to the completion flag, and that write launches the operation. When the step is over, the controller sets the flag again. It keeps SCL pulled low until software writes the flag once more, so the bus waits on software at every byte.

Both lines are open-drain. The controller pulls a line low by asserting its output enable and reads the real line level back. The first byte after a START is always transmitted. Its least significant bit chooses the direction of the bytes that follow: 0 means write, 1 means read. Received bytes are acknowledged or refused according to the enable-acknowledge bit.

The controller watches for another master winning arbitration. It also rejects data writes made while a step is still in flight and reports them as a write collision. A status code tells how each step ended. An interrupt request is formed from the flag, a local interrupt enable and a global interrupt-enable input.

Top module: `i2c_flag_master`

## Requirements
- R1: After reset the control register, the data register and the status code are 0, both line enables are low and `irq_o` is 0.
- R2: The SCL period in system clocks is 16 + 2 × divisor (divisor written with `wr_sel_i` = 0). The high and low halves are equal.
- R3: A control write (`wr_sel_i` = 1) with bit 7 (flag), bit 5 (START) and bit 2 (enable) set does two things. It puts a START condition on the bus, meaning SDA falls while SCL is high. This works from an idle bus and, as a repeated START, from a held bus. It then sets the flag, reports status 1 and holds SCL low.
- R4: While the flag is set, SCL is held low, except after an arbitration loss. The flag clears only when a control write has bit 7 set. A control write with bit 7 clear leaves the flag set.
- R5: A byte launch (control write with bit 7 and bit 2 set, bits 5 and 4 clear) sends the data register MSB first. An ACK from the slave gives status 2 and a NACK gives status 3. Bit 0 of the first byte after a START selects receive (1) for the bytes that follow.
- R6: In receive direction, eight bits are sampled MSB first into the data register. On the ninth clock the controller pulls SDA low if control bit 6 is set and releases it otherwise. The status is 4 or 5 respectively.
- R7: A data write (`wr_sel_i` = 2) made while the flag is 0 sets control bit 3 and leaves the data register unchanged. A data write made while the flag is 1 loads the register and clears bit 3. Control writes cannot set bit 3.
- R8: If the controller releases SDA during a transmitted data bit but samples it low, it releases both lines, sets the flag and reports status 6.
- R9: A launch with bit 4 (STOP) set puts a STOP condition on the bus, meaning SDA rises while SCL is high. It then releases both lines, clears bit 4 by itself and does not set the flag.
- R10: `irq_o` is 1 exactly when the flag, control bit 0 and `gie_i` are all 1.
- R11: Clearing control bit 2 aborts the current step and releases both lines within two cycles, without setting the flag.
- R12: During byte transfers, SDA changes only while SCL is low, so no START or STOP condition appears except on request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 divisor, 1 control, 2 data |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register: 7 flag, 6 ack enable, 5 START, 4 STOP, 3 write collision, 2 enable, 1 reads 0, 0 interrupt enable |
| data_o | output | 8 | Data register |
| status_o | output | 3 | Result code of the last step |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with its default parameters, an 8-bit divisor and a base half period of 8 clocks. Divisor values are drawn from 0 to 5 so that many bytes fit in a short run. One byte runs at divisor 255, which exercises the widest half-period count and the full 526-clock period. A bench-side slave acknowledges, refuses, sends bytes and forces an arbitration loss at a chosen bit. This brings every status code and both line-release paths within reach.

// File: rtl/i2cfm_pkg.sv
package i2cfm_pkg;
  localparam int unsigned CB_FLAG  = 7;
  localparam int unsigned CB_ACKEN = 6;
  localparam int unsigned CB_START = 5;
  localparam int unsigned CB_STOP  = 4;
  localparam int unsigned CB_WCOL  = 3;
  localparam int unsigned CB_EN    = 2;
  localparam int unsigned CB_IE    = 0;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef enum logic [2:0] {
    ST_NONE    = 3'd0,
    ST_START   = 3'd1,
    ST_TX_ACK  = 3'd2,
    ST_TX_NACK = 3'd3,
    ST_RX_ACK  = 3'd4,
    ST_RX_NACK = 3'd5,
    ST_ARB     = 3'd6
  } stat_e;

  typedef enum logic [2:0] {
    E_IDLE, E_HOLD, E_START, E_STOP, E_LO, E_HI
  } eng_e;
endpackage

// File: rtl/i2cfm_baud.sv
module i2cfm_baud #(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned HALF_BASE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stall_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             first_o
);
  localparam int unsigned CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt_q, half_m1;

  assign half_m1 = CNT_W'(HALF_BASE) + CNT_W'(div_i) - CNT_W'(1);
  assign tick_o  = run_i && !stall_i && (cnt_q == half_m1);
  assign first_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!stall_i) cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/i2cfm_regs.sv
module i2cfm_regs
  import i2cfm_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             stop_done_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  output logic [DIV_W-1:0] div_o,
  output logic [7:0]       ctrl_o,
  output logic [7:0]       data_o,
  output logic             launch_o,
  output logic             launch_sta_o,
  output logic             launch_sto_o,
  output logic             en_o,
  output logic             ea_o
);
  logic flag_q, ea_q, sta_q, sto_q, wcol_q, en_q, ie_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0] data_q;
  logic wr_ctrl, wr_data, wr_div;

  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_data = wr_en_i && (wr_sel_i == SEL_DATA);
  assign wr_div  = wr_en_i && (wr_sel_i == SEL_DIV);

  assign launch_o     = wr_ctrl && wr_data_i[CB_FLAG] && wr_data_i[CB_EN] && !busy_i;
  assign launch_sta_o = wr_data_i[CB_START];
  assign launch_sto_o = wr_data_i[CB_STOP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0; ea_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      wcol_q <= 1'b0; en_q <= 1'b0; ie_q <= 1'b0;
      div_q  <= '0;   data_q <= '0;
    end else begin
      if (done_i)                             flag_q <= 1'b1;
      else if (wr_ctrl && wr_data_i[CB_FLAG]) flag_q <= 1'b0;
      if (wr_ctrl) begin
        ea_q  <= wr_data_i[CB_ACKEN];
        sta_q <= wr_data_i[CB_START];
        sto_q <= wr_data_i[CB_STOP];
        en_q  <= wr_data_i[CB_EN];
        ie_q  <= wr_data_i[CB_IE];
      end
      if (stop_done_i) sto_q <= 1'b0;
      if (wr_div)      div_q <= wr_data_i[DIV_W-1:0];
      if (rx_valid_i)  data_q <= rx_byte_i;
      if (wr_data) begin
        if (flag_q) begin
          data_q <= wr_data_i;
          wcol_q <= 1'b0;
        end else begin
          wcol_q <= 1'b1;
        end
      end
    end
  end

  assign div_o  = div_q;
  assign data_o = data_q;
  assign en_o   = en_q;
  assign ea_o   = ea_q;
  assign ctrl_o = {flag_q, ea_q, sta_q, sto_q, wcol_q, en_q, 1'b0, ie_q};

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_ctrl && wr_data_i[CB_FLAG])) |=> flag_q);
  // R7
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !flag_q) |=> wcol_q);
  // R9
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_done_i && !wr_ctrl) |=> !sto_q);
endmodule

// File: rtl/i2cfm_engine.sv
module i2cfm_engine
  import i2cfm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       launch_i,
  input  logic       sta_i,
  input  logic       sto_i,
  input  logic [7:0] tx_i,
  input  logic       ea_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       tick_i,
  input  logic       first_i,
  output logic       busy_o,
  output logic       stall_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic       stop_done_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output stat_e      status_o
);
  eng_e       state_q;
  logic [1:0] step_q;
  logic [3:0] bitn_q;
  logic [7:0] tx_q, sh_q;
  logic       scl_oe_q, sda_oe_q, is_rx_q, rd_mode_q, addr_next_q;
  logic       done_q, stop_q, rxv_q, drv;
  stat_e      status_q;

  assign busy_o  = (state_q == E_START) || (state_q == E_STOP) ||
                   (state_q == E_LO)    || (state_q == E_HI);
  assign stall_o = !scl_oe_q && !scl_i;

  // Value to put on SDA for the current bit (1 = pull low)
  always_comb begin
    if (is_rx_q) drv = (bitn_q == 4'd8) && ea_i;
    else         drv = (bitn_q != 4'd8) && !tx_q[3'd7 - bitn_q[2:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_IDLE; step_q <= '0; bitn_q <= '0; tx_q <= '0; sh_q <= '0;
      scl_oe_q <= 1'b0; sda_oe_q <= 1'b0; is_rx_q <= 1'b0; rd_mode_q <= 1'b0;
      addr_next_q <= 1'b0; done_q <= 1'b0; stop_q <= 1'b0; rxv_q <= 1'b0;
      status_q <= ST_NONE;
    end else begin
      done_q <= 1'b0;
      stop_q <= 1'b0;
      rxv_q  <= 1'b0;
      if (launch_i) begin
        if (sta_i) begin
          state_q  <= E_START;
          step_q   <= '0;
          sda_oe_q <= 1'b0;
        end else if (sto_i) begin
          if (state_q == E_HOLD) begin
            state_q  <= E_STOP;
            step_q   <= '0;
            sda_oe_q <= 1'b1;
          end else begin
            stop_q <= 1'b1;
          end
        end else if (state_q == E_HOLD) begin
          state_q <= E_LO;
          bitn_q  <= '0;
          is_rx_q <= !addr_next_q && rd_mode_q;
          tx_q    <= tx_i;
        end
      end else if (!en_i) begin
        state_q  <= E_IDLE;
        scl_oe_q <= 1'b0;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          E_START: if (tick_i) begin
            step_q <= step_q + 2'd1;
            unique case (step_q)
              2'd0: scl_oe_q <= 1'b0;
              2'd1: sda_oe_q <= 1'b1;
              2'd2: scl_oe_q <= 1'b1;
              default: begin
                state_q     <= E_HOLD;
                done_q      <= 1'b1;
                status_q    <= ST_START;
                addr_next_q <= 1'b1;
              end
            endcase
          end
          E_STOP: if (tick_i) begin
            step_q <= step_q + 2'd1;
            if (step_q == 2'd0) begin
              scl_oe_q <= 1'b0;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= E_IDLE;
              stop_q   <= 1'b1;
            end
          end
          E_LO: begin
            if (first_i) sda_oe_q <= drv;
            if (tick_i) begin
              state_q  <= E_HI;
              scl_oe_q <= 1'b0;
            end
          end
          E_HI: if (tick_i) begin
            if (!is_rx_q && (bitn_q != 4'd8) && !sda_oe_q && !sda_i) begin
              state_q  <= E_IDLE;
              scl_oe_q <= 1'b0;
              sda_oe_q <= 1'b0;
              done_q   <= 1'b1;
              status_q <= ST_ARB;
            end else if (bitn_q == 4'd8) begin
              state_q  <= E_HOLD;
              scl_oe_q <= 1'b1;
              done_q   <= 1'b1;
              if (is_rx_q) begin
                rxv_q    <= 1'b1;
                status_q <= ea_i ? ST_RX_ACK : ST_RX_NACK;
              end else begin
                status_q <= sda_i ? ST_TX_NACK : ST_TX_ACK;
                if (addr_next_q) rd_mode_q <= tx_q[0];
              end
              addr_next_q <= 1'b0;
            end else begin
              if (is_rx_q) sh_q <= {sh_q[6:0], sda_i};
              bitn_q   <= bitn_q + 4'd1;
              state_q  <= E_LO;
              scl_oe_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe_o    = scl_oe_q;
  assign sda_oe_o    = sda_oe_q;
  assign done_o      = done_q;
  assign stop_done_o = stop_q;
  assign rx_valid_o  = rxv_q;
  assign rx_byte_o   = sh_q;
  assign status_o    = status_q;

  // R4
  hold_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_HOLD) |-> scl_oe_q);
  // R8 R11
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_IDLE) |-> (!scl_oe_q && !sda_oe_q));
  // R12
  sda_still_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == E_HI) |-> $stable(sda_oe_q));
  // R3
  start_from_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && sta_i) |=> (state_q == E_START));
endmodule

// File: rtl/i2c_flag_master.sv
module i2c_flag_master
  import i2cfm_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned HALF_BASE = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gie_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic [2:0] status_o,
  output logic       irq_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic [DIV_W-1:0] div;
  logic launch, l_sta, l_sto, en, ea, busy, stall, tick, first;
  logic done, stop_done, rx_valid;
  logic [7:0] rx_byte, ctrl, data;
  stat_e status;

  i2cfm_regs #(.DIV_W(DIV_W)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .busy_i(busy), .done_i(done), .stop_done_i(stop_done),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .div_o(div), .ctrl_o(ctrl), .data_o(data),
    .launch_o(launch), .launch_sta_o(l_sta), .launch_sto_o(l_sto),
    .en_o(en), .ea_o(ea)
  );

  i2cfm_baud #(.DIV_W(DIV_W), .HALF_BASE(HALF_BASE)) baud_i (
    .clk_i, .rst_ni, .run_i(busy), .stall_i(stall), .div_i(div),
    .tick_o(tick), .first_o(first)
  );

  i2cfm_engine engine_i (
    .clk_i, .rst_ni, .en_i(en), .launch_i(launch), .sta_i(l_sta), .sto_i(l_sto),
    .tx_i(data), .ea_i(ea), .scl_i, .sda_i, .tick_i(tick), .first_i(first),
    .busy_o(busy), .stall_o(stall), .scl_oe_o, .sda_oe_o,
    .done_o(done), .stop_done_o(stop_done), .rx_valid_o(rx_valid),
    .rx_byte_o(rx_byte), .status_o(status)
  );

  assign ctrl_o   = ctrl;
  assign data_o   = data;
  assign status_o = status;
  assign irq_o    = ctrl[CB_FLAG] && ctrl[CB_IE] && gie_i;

  // R4
  flag_holds_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[CB_FLAG] && ctrl[CB_EN] && (status != ST_ARB) && !busy) |-> scl_oe_o);
endmodule

// File: tb/i2c_flag_master_tb_top.sv
`timescale 1ns/1ps
module i2c_flag_master_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic gie_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] ctrl_o, data_o;
  logic [2:0] status_o;
  logic irq_o, scl_oe_o, sda_oe_o;
  logic scl_line, sda_line, sl_drive;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #2 clk_i = ~clk_i;

  i2c_flag_master dut_i (
    .clk_i, .rst_ni, .gie_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ctrl_o, .data_o, .status_o, .irq_o,
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o, .sda_oe_o
  );

  // Bus-level slave model: 0 receive (acks with sl_ack), 1 send sl_tx, 2 force low at arb_idx
  int         sl_mode = 0;
  logic       sl_ack = 1'b1;
  logic [7:0] sl_tx = '0;
  logic [3:0] arb_idx = 4'd0;
  logic [3:0] cur = 4'd15;
  logic [7:0] cap = '0;
  logic       ack_seen = 1'b1;
  logic       scl_p = 1'b1, sda_p = 1'b1;
  int cyc = 0, last_rise = 0, per = 0, start_cnt = 0, stop_cnt = 0;

  always_comb begin
    sl_drive = 1'b0;
    if (cur <= 4'd8) begin
      case (sl_mode)
        0: sl_drive = (cur == 4'd8) && sl_ack;
        1: sl_drive = (cur != 4'd8) && !sl_tx[3'd7 - cur[2:0]];
        2: sl_drive = (cur == arb_idx);
        default: sl_drive = 1'b0;
      endcase
    end
  end
  assign scl_line = !scl_oe_o;
  assign sda_line = !(sda_oe_o || sl_drive);

  always @(posedge clk_i) begin
    cyc   <= cyc + 1;
    scl_p <= scl_line;
    sda_p <= sda_line;
    if (scl_line && !scl_p) begin
      if (cur < 4'd8)       cap <= {cap[6:0], sda_line};
      else if (cur == 4'd8) ack_seen <= sda_line;
      per       <= cyc - last_rise;
      last_rise <= cyc;
    end
    if (!scl_line && scl_p) cur <= (cur >= 4'd8) ? 4'd0 : cur + 4'd1;
    if (scl_line && scl_p && sda_p && !sda_line) begin
      start_cnt <= start_cnt + 1;
      cur       <= 4'd15;
    end
    if (scl_line && scl_p && !sda_p && sda_line) stop_cnt <= stop_cnt + 1;
  end

  function automatic int exp_period(input int d);
    return 16 + 2 * d;
  endfunction
  function automatic int exp_tx_stat(input bit ack);
    return ack ? 2 : 3;
  endfunction
  function automatic int exp_rx_stat(input bit ea);
    return ea ? 4 : 5;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk_i);
      if (ctrl_o[7]) seen = 1'b1;
    end
    chk(req, "flag raised", int'(seen), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int d, hold_ok, stop_ok;
    logic [7:0] b, addr;
    bit ack, ea;
    void'($urandom(32'h5eed_1c2a));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "ctrl", int'(ctrl_o), 0);
    chk("R1", "data", int'(data_o), 0);
    chk("R1", "status", int'(status_o), 0);
    chk("R1", "line enables", int'({scl_oe_o, sda_oe_o}), 0);
    chk("R1", "irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7 data write while flag low
    wr(2'd2, 8'h3C);
    chk("R7", "wcol after early write", int'(ctrl_o[3]), 1);
    chk("R7", "data untouched", int'(data_o), 0);

    d = int'($urandom % 6);
    wr(2'd0, 8'(d));
    gie_i = 1'b1;
    wr(2'd1, 8'hA5);
    wait_flag("R3");
    chk("R3", "status after START", int'(status_o), 1);
    chk("R3", "START conditions", start_cnt, 1);
    hold_ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (!scl_oe_o) hold_ok = 0;
    end
    chk("R4", "SCL held while flag set", hold_ok, 1);
    chk("R10", "irq with gie", int'(irq_o), 1);
    gie_i = 1'b0;
    @(negedge clk_i);
    chk("R10", "irq without gie", int'(irq_o), 0);
    gie_i = 1'b1;
    wr(2'd1, 8'h05);
    chk("R4", "flag kept on write of 0", int'(ctrl_o[7]), 1);
    chk("R10", "irq tracks flag and ie", int'(irq_o), 1);

    addr = {7'($urandom), 1'b0};
    wr(2'd2, addr);
    chk("R7", "wcol cleared", int'(ctrl_o[3]), 0);
    chk("R7", "data loaded", int'(data_o), int'(addr));
    sl_mode = 0; sl_ack = 1'b1;
    wr(2'd1, 8'h85);
    wait_flag("R5");
    chk("R5", "address on bus", int'(cap), int'(addr));
    chk("R5", "address status", int'(status_o), exp_tx_stat(1'b1));
    chk("R2", "SCL period", per, exp_period(d));

    for (int i = 0; i < 6; i++) begin
      d = (i == 2) ? 255 : int'($urandom % 6);
      wr(2'd0, 8'(d));
      b = 8'($urandom);
      ack = 1'($urandom);
      sl_ack = ack;
      wr(2'd2, b);
      wr(2'd1, 8'h85);
      wait_flag("R5");
      chk("R5", "tx byte on bus", int'(cap), int'(b));
      chk("R5", "tx status", int'(status_o), exp_tx_stat(ack));
      chk("R2", "SCL period", per, exp_period(d));
    end
    chk("R12", "no stray START", start_cnt, 1);
    chk("R12", "no stray STOP", stop_cnt, 0);

    // R3 repeated START, then read direction
    wr(2'd0, 8'd2);
    wr(2'd1, 8'hA5);
    wait_flag("R3");
    chk("R3", "repeated START status", int'(status_o), 1);
    chk("R3", "repeated START seen", start_cnt, 2);
    addr = {7'($urandom), 1'b1};
    sl_ack = 1'b1;
    wr(2'd2, addr);
    wr(2'd1, 8'h85);
    wait_flag("R5");
    chk("R5", "read address status", int'(status_o), 2);
    for (int j = 0; j < 3; j++) begin
      b = 8'($urandom);
      ea = (j < 2);
      sl_mode = 1; sl_tx = b;
      wr(2'd1, ea ? 8'hC5 : 8'h85);
      wait_flag("R6");
      chk("R6", "rx byte", int'(data_o), int'(b));
      chk("R6", "rx status", int'(status_o), exp_rx_stat(ea));
      chk("R6", "ninth bit level", int'(ack_seen), int'(!ea));
    end

    // R9 STOP
    sl_mode = 0; sl_ack = 1'b0;
    wr(2'd1, 8'h94);
    stop_ok = 0;
    for (int i = 0; i < 20000 && !stop_ok; i++) begin
      @(negedge clk_i);
      if (!ctrl_o[4]) stop_ok = 1;
    end
    chk("R9", "STOP bit self-cleared", stop_ok, 1);
    chk("R9", "STOP condition", stop_cnt, 1);
    chk("R9", "flag not set", int'(ctrl_o[7]), 0);
    chk("R9", "lines released", int'({scl_oe_o, sda_oe_o}), 0);
    chk("R12", "START count stable", start_cnt, 2);

    // R8 arbitration loss
    wr(2'd0, 8'd1);
    wr(2'd1, 8'hA4);
    wait_flag("R8");
    wr(2'd2, 8'hF0);
    sl_mode = 2; arb_idx = 4'd2;
    wr(2'd1, 8'h84);
    wait_flag("R8");
    chk("R8", "arbitration status", int'(status_o), 6);
    chk("R8", "lines released", int'({scl_oe_o, sda_oe_o}), 0);
    sl_mode = 0;
    wr(2'd1, 8'h0C);
    chk("R7", "wcol not writable", int'(ctrl_o[3]), 0);
    chk("R4", "flag kept", int'(ctrl_o[7]), 1);

    // R11 abort by clearing enable
    wr(2'd1, 8'hA4);
    wait_flag("R11");
    wr(2'd2, 8'h55);
    wr(2'd1, 8'h84);
    repeat (30) @(negedge clk_i);
    wr(2'd1, 8'h00);
    @(negedge clk_i);
    chk("R11", "lines released", int'({scl_oe_o, sda_oe_o}), 0);
    repeat (100) @(negedge clk_i);
    chk("R11", "flag stays clear", int'(ctrl_o[7]), 0);
    chk("R11", "lines stay released", int'({scl_oe_o, sda_oe_o}), 0);

    report();
    $finish;
  end
endmodule